// File: doc/BRIEF.md
# Instruction Prefetch Queue with Memory Bus Arbiter

This block is the instruction-fetch front end of a small processor's memory controller. It keeps a short byte-wide queue of instruction bytes ahead of the execution unit. A private fetch-address counter supplies the address for every refill, and after each refill it steps to the next byte address, so sequential fetching never waits on the execution unit. One memory port is shared between queue refills and the execution unit's data loads and stores. A fixed-priority arbiter always serves the queue first.

The execution unit takes instruction bytes through a valid/byte/pop interface and sees nothing else of the queue. A redirect (taken branch, call, return or interrupt entry) loads a new target into the fetch counter and empties the queue. A refill read that is still in flight when the redirect arrives is dropped. The memory port always accepts a request, and it returns read data in the cycle after the request.

Top module: `prefetch_frontend`

## Requirements
- R1: While reset is held, the fetch counter loads `reset_vector` and the queue is empty. In the first cycle after reset is released, `q_valid` is 0 and a refill read (`mem_req`=1, `mem_we`=0) is driven at address `reset_vector`.
- R2: Each refill reads the byte at the fetch counter's address, and the counter then advances by one. Bytes are presented on `q_byte` strictly in address order. A refill issued in cycle c makes its byte visible in cycle c+2.
- R3: When a refill and a data access are both eligible in the same cycle, the refill is granted and the data access waits.
- R4: The queue holds 4 bytes. It stops requesting when its stored bytes plus any refill in flight reach 4. The data side is then granted the port.
- R5: A granted data access drives `d_addr`, `d_we`, `d_wide` and `d_wdata` onto the memory port. `d_done` pulses in the next cycle and never in two consecutive cycles. For a read, `d_rdata` carries both bytes in that cycle when `d_wide`=1 (little-endian: the byte at `d_addr` is in bits 7:0). When `d_wide`=0 it carries `{8'h00, byte}`.
- R6: A redirect in cycle c loads `redir_addr` into the fetch counter and flushes the queue. `q_valid` is 0 in cycle c+1, and the first refill at `redir_addr` is issued in cycle c+1.
- R7: A refill byte that returns in the cycle of a redirect is discarded. After a redirect, the first byte presented is the byte at `redir_addr`.
- R8: `q_pop` has no effect while `q_valid` is 0 or while `redir` is 1. No byte is skipped because of such a pop.
- R9: No refill is requested in a cycle in which `redir` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reset_vector | input | AW | Fetch address loaded during reset |
| redir | input | 1 | Redirect strobe: load new fetch address and flush |
| redir_addr | input | AW | Redirect target address |
| q_valid | output | 1 | A byte is available at the queue head |
| q_byte | output | 8 | Byte at the queue head |
| q_pop | input | 1 | Consume the head byte |
| d_req | input | 1 | Data access request, held until `d_done` |
| d_addr | input | AW | Data access address |
| d_we | input | 1 | 1 = write, 0 = read |
| d_wide | input | 1 | 1 = 16-bit access, 0 = byte access |
| d_wdata | input | 16 | Write data |
| d_done | output | 1 | Data access completed |
| d_rdata | output | 16 | Read data, valid with `d_done` |
| mem_req | output | 1 | Memory access this cycle |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write enable |
| mem_wide | output | 1 | Memory access is 16-bit |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, one cycle after the request |

## Verification
The bench starts with a data read pending at the moment reset is released. The read must wait through exactly four refills and then complete. A design that let the data side in early, or that kept fetching past four bytes, shows a wrong address or wrong `d_done` timing. A redirect is placed in the cycle where a refill returns, and pop is held high while the queue is empty. A design that kept the stale byte, or that popped a nonexistent head, then presents a byte other than the target's. Long random runs mix pops, redirects and byte/word reads and writes, and compare every consumed byte against a model of the program-order address.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_QUEUE = 2'd1,
    SRC_DATA  = 2'd2
  } bus_src_t;
endpackage

// File: rtl/fetch_counter.sv
module fetch_counter #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vector,
  input  logic          load,
  input  logic [AW-1:0] target,
  input  logic          step,
  output logic [AW-1:0] pc
);
  always_ff @(posedge clk) begin
    if (rst)       pc <= reset_vector;
    else if (load) pc <= target;
    else if (step) pc <= pc + AW'(1);
  end

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> (pc == $past(pc) + AW'(1)));
  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> (pc == $past(target)));
endmodule

// File: rtl/byte_queue.sv
module byte_queue #(
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic                       wr_en,
  input  logic [7:0]                 wr_byte,
  input  logic                       rd_en,
  output logic                       valid,
  output logic [7:0]                 rd_byte,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          do_pop;

  assign valid   = (count != '0);
  assign do_pop  = rd_en && valid;
  assign rd_byte = store[rp];

  always_ff @(posedge clk) begin
    if (wr_en) store[wp] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (wr_en)  wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (do_pop) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({wr_en, do_pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !do_pop && !flush) |-> (count < CW'(DEPTH)));
  assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  assert_empty_pop_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !valid && !wr_en && !flush) |=> (count == '0));
  assert_flush_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> !valid);
endmodule

// File: rtl/bus_arbiter.sv
module bus_arbiter
  import pf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic q_req,
  input  logic d_req,
  output logic q_gnt,
  output logic d_gnt,
  output logic q_ret,
  output logic d_done
);
  bus_src_t src;

  always_comb begin
    src = SRC_NONE;
    if (q_req)                 src = SRC_QUEUE;
    else if (d_req && !d_done) src = SRC_DATA;
  end

  assign q_gnt = (src == SRC_QUEUE);
  assign d_gnt = (src == SRC_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_ret  <= 1'b0;
      d_done <= 1'b0;
    end else begin
      q_ret  <= q_gnt;
      d_done <= d_gnt;
    end
  end

  assert_one_owner_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({q_gnt, d_gnt}));
  assert_queue_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (q_req && d_req) |-> !d_gnt);
  assert_done_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    d_done |=> !d_done);
endmodule

// File: rtl/prefetch_frontend.sv
module prefetch_frontend #(
  parameter int AW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] reset_vector,
  input  logic          redir,
  input  logic [AW-1:0] redir_addr,
  output logic          q_valid,
  output logic [7:0]    q_byte,
  input  logic          q_pop,
  input  logic          d_req,
  input  logic [AW-1:0] d_addr,
  input  logic          d_we,
  input  logic          d_wide,
  input  logic [15:0]   d_wdata,
  output logic          d_done,
  output logic [15:0]   d_rdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_wide,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] pc;
  logic [CW-1:0] count;
  logic [CW:0]   occupancy;
  logic          q_req, q_gnt, d_gnt, q_ret, fill, wide_q;

  assign occupancy = {1'b0, count} + (CW+1)'(q_ret);
  assign q_req     = !redir && (occupancy < (CW+1)'(DEPTH));
  assign fill      = q_ret && !redir;

  fetch_counter #(.AW(AW)) u_ctr (
    .clk(clk), .rst(rst), .reset_vector(reset_vector),
    .load(redir), .target(redir_addr), .step(q_gnt), .pc(pc)
  );

  bus_arbiter u_arb (
    .clk(clk), .rst(rst), .q_req(q_req), .d_req(d_req),
    .q_gnt(q_gnt), .d_gnt(d_gnt), .q_ret(q_ret), .d_done(d_done)
  );

  byte_queue #(.DEPTH(DEPTH)) u_q (
    .clk(clk), .rst(rst), .flush(redir), .wr_en(fill),
    .wr_byte(mem_rdata[7:0]), .rd_en(q_pop && !redir),
    .valid(q_valid), .rd_byte(q_byte), .count(count)
  );

  always_ff @(posedge clk) begin
    if (rst)        wide_q <= 1'b0;
    else if (d_gnt) wide_q <= d_wide;
  end

  assign mem_req   = q_gnt || d_gnt;
  assign mem_addr  = q_gnt ? pc : d_addr;
  assign mem_we    = d_gnt && d_we;
  assign mem_wide  = d_gnt && d_wide;
  assign mem_wdata = d_gnt ? d_wdata : 16'h0000;
  assign d_rdata   = !d_done ? 16'h0000 :
                     (wide_q ? mem_rdata : {8'h00, mem_rdata[7:0]});

  assert_no_fetch_on_redirect_R9: assert property (@(posedge clk) disable iff (rst)
    redir |-> !(mem_req && !d_gnt));
  assert_valid_drops_R6: assert property (@(posedge clk) disable iff (rst)
    redir |=> !q_valid);
  assert_stale_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (redir && q_ret) |=> (count == '0));
endmodule

// File: tb/prefetch_frontend_test.sv
module prefetch_frontend_test;
  localparam int AW = 16;
  localparam time CLK = 8ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] reset_vector = 16'hF000;
  logic          redir = 1'b0;
  logic [AW-1:0] redir_addr = '0;
  logic          q_valid, q_pop = 1'b0;
  logic [7:0]    q_byte;
  logic          d_req = 1'b0, d_we = 1'b0, d_wide = 1'b0;
  logic [AW-1:0] d_addr = '0;
  logic [15:0]   d_wdata = '0;
  logic          d_done;
  logic [15:0]   d_rdata;
  logic          mem_req, mem_we, mem_wide;
  logic [AW-1:0] mem_addr, lat_addr = '0;
  logic [15:0]   mem_wdata, mem_rdata;

  int  checks = 0, errors = 0;
  bit  finished = 1'b0;
  logic [AW-1:0] exp_addr;
  bit  dseen;

  always #(CLK/2) clk = ~clk;

  function automatic logic [7:0] bval(input logic [AW-1:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  always @(posedge clk) lat_addr <= mem_addr;
  assign mem_rdata = {bval(lat_addr + 16'd1), bval(lat_addr)};

  prefetch_frontend #(.AW(AW), .DEPTH(4)) uut (
    .clk(clk), .rst(rst), .reset_vector(reset_vector), .redir(redir),
    .redir_addr(redir_addr), .q_valid(q_valid), .q_byte(q_byte), .q_pop(q_pop),
    .d_req(d_req), .d_addr(d_addr), .d_we(d_we), .d_wide(d_wide),
    .d_wdata(d_wdata), .d_done(d_done), .d_rdata(d_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) tick();
    // data read pending at reset release; no pops
    d_req = 1'b1; d_addr = 16'h1234; d_we = 1'b0; d_wide = 1'b1;
    rst = 1'b0;
    #1;
    chk(mem_req && !mem_we && mem_addr == 16'hF000, "R1 first fetch", mem_addr, 16'hF000);
    chk(!q_valid, "R1 empty after reset", q_valid, 0);
    for (int k = 1; k <= 3; k++) begin
      tick(); #1;
      chk(mem_req && !mem_we && mem_addr == 16'hF000 + k[15:0], "R2 R3 fetch order",
          mem_addr, 16'hF000 + k[15:0]);
      if (k == 1) chk(!q_valid, "R2 latency", q_valid, 0);
      if (k == 2) chk(q_valid && q_byte == bval(16'hF000), "R2 first byte", q_byte, bval(16'hF000));
      chk(!d_done, "R3 data waits", d_done, 0);
    end
    tick(); #1;
    chk(mem_req && !mem_we && mem_addr == 16'h1234, "R4 data granted when full", mem_addr, 16'h1234);
    tick(); #1;
    chk(d_done && d_rdata == {bval(16'h1235), bval(16'h1234)}, "R5 word read",
        d_rdata, {bval(16'h1235), bval(16'h1234)});
    chk(!mem_req, "R4 no fetch beyond depth", mem_req, 0);
    tick(); d_req = 1'b0;
    tick(); d_req = 1'b1; d_we = 1'b1; d_wide = 1'b0; d_addr = 16'h0042; d_wdata = 16'hBEEF;
    #1;
    chk(mem_req && mem_we && !mem_wide && mem_addr == 16'h0042 && mem_wdata == 16'hBEEF,
        "R5 write fields", {mem_addr, mem_wdata}, {16'h0042, 16'hBEEF});
    tick(); #1;
    chk(d_done, "R5 write done", d_done, 1);
    tick(); d_we = 1'b0; d_addr = 16'h0077;
    #1;
    chk(!d_done, "R5 done single pulse", d_done, 0);
    tick(); #1;
    chk(d_done && d_rdata == {8'h00, bval(16'h0077)}, "R5 byte read",
        d_rdata, {8'h00, bval(16'h0077)});
    tick(); d_req = 1'b0;
    // drain four bytes in order
    for (int i = 0; i < 4; i++) begin
      tick(); q_pop = 1'b1; #1;
      chk(q_valid && q_byte == bval(16'hF000 + i[15:0]), "R2 program order",
          q_byte, bval(16'hF000 + i[15:0]));
    end
    // redirect in the cycle a refill returns
    tick(); q_pop = 1'b0; redir = 1'b1; redir_addr = 16'h2000; #1;
    chk(!mem_req, "R9 no fetch during redirect", mem_req, 0);
    tick(); redir = 1'b0; q_pop = 1'b1; #1;
    chk(!q_valid, "R6 valid low after redirect", q_valid, 0);
    chk(mem_req && mem_addr == 16'h2000, "R6 fetch at target", mem_addr, 16'h2000);
    tick(); #1;
    chk(!q_valid, "R8 pop while empty", q_valid, 0);
    tick(); #1;
    chk(q_valid && q_byte == bval(16'h2000), "R7 stale byte dropped", q_byte, bval(16'h2000));
    exp_addr = 16'h2001;
    dseen = 1'b0;
    // random phase
    for (int n = 0; n < 4000; n++) begin
      tick();
      q_pop = (($urandom % 10) < 7);
      redir = (($urandom % 100) < 3);
      redir_addr = 16'($urandom);
      if (dseen) begin d_req = 1'b0; dseen = 1'b0; end
      if (!d_req && ($urandom % 8) == 0) begin
        d_req = 1'b1; d_we = $urandom % 2; d_wide = $urandom % 2;
        d_addr = 16'($urandom); d_wdata = 16'($urandom);
      end
      #1;
      if (redir) begin
        chk(!mem_req || (d_req && mem_addr == d_addr), "R9 random redirect", mem_addr, d_addr);
        exp_addr = redir_addr;
      end else if (q_pop && q_valid) begin
        chk(q_byte == bval(exp_addr), "R2 R7 random order", q_byte, bval(exp_addr));
        exp_addr = exp_addr + 16'd1;
      end
      if (mem_req && mem_we)
        chk(mem_addr == d_addr && mem_wdata == d_wdata && mem_wide == d_wide,
            "R5 random write", {mem_addr, mem_wdata}, {d_addr, d_wdata});
      if (d_done) begin
        dseen = 1'b1;
        if (!d_we)
          chk(d_rdata == (d_wide ? {bval(d_addr + 16'd1), bval(d_addr)} : {8'h00, bval(d_addr)}),
              "R5 random read", d_rdata,
              d_wide ? {bval(d_addr + 16'd1), bval(d_addr)} : {8'h00, bval(d_addr)});
      end
    end
    finished = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule